// File: doc/BRIEF.md
# Fractional Divider Clock Mux

This block produces the clock enable for one peripheral. All of its inputs live in a single fast reference clock domain. Each source clock is represented as a one-cycle enable strobe. A control input picks one of up to 16 such strobes. The picked strobe is then divided by a fixed-point divisor, so the output strobe's long-run rate is the source rate times 2^FRAC_BITS divided by the divisor.

The divisor is read out of a 32-bit divider word. Its integer part always begins at bit 12, and its fractional part sits in the FRAC_BITS bits just below bit 12. Each instance chooses INT_BITS and FRAC_BITS for itself. If both are zero, the instance has no divider and the picked strobe passes straight through.

A first-order phase accumulator spreads the fractional remainder over time. A busy flag reports whether the block is running.

Top module: `frac_clkdiv_mux`

## Requirements
- R1: While `ctl_enable` is low, `out_tick` stays low and the accumulator is cleared.
- R2: `busy` equals the value `ctl_enable` had at the previous rising clock edge. It is 0 during reset.
- R3: `ctl_src_sel` maps sources as follows. Code 0 is ground (never strobes). Code 1 is `osc_tick`, code 2 is `test0_tick` and code 3 is `test1_tick`. Code 4+k is `ext_tick[k]` for k < NUM_EXT.
- R4: A select code at or above 4+NUM_EXT picks ground, so no output strobe is ever produced.
- R5: The divisor is `div_word[12+INT_BITS-1 : 12-FRAC_BITS]`, read as an unsigned value. Every other bit of `div_word` has no effect.
- R6: Consider a picked strobe in a cycle with a nonzero, unchanged divisor D and an unchanged select. The accumulator A becomes S = A + 2^FRAC_BITS. If S >= D, the block emits `out_tick` one cycle later and A becomes S - D. Otherwise A becomes S and there is no output.
- R7: A divisor of zero produces no output strobes.
- R8: A divisor below 2^FRAC_BITS (a ratio under one) gives exactly one output strobe per picked source strobe, and the accumulator stays at zero.
- R9: In any cycle where the select or the divisor differs from its value in the previous cycle, the accumulator is cleared and no output strobe is generated. A source strobe in that cycle is dropped.
- R10: An instance with INT_BITS = FRAC_BITS = 0 drives `out_tick` one cycle after each picked strobe while enabled, whatever `div_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Run enable |
| ctl_src_sel | input | SEL_W | Source select code |
| div_word | input | 32 | Divider word holding the fixed-point divisor |
| osc_tick | input | 1 | Main oscillator strobe (code 1) |
| test0_tick | input | 1 | Test clock 0 strobe (code 2) |
| test1_tick | input | 1 | Test clock 1 strobe (code 3) |
| ext_tick | input | NUM_EXT | Instance-specific source strobes (codes 4 and up) |
| out_tick | output | 1 | Divided output strobe |
| busy | output | 1 | Registered copy of the enable |

## Verification
If the accumulator holds a wrong value, the output strobes move away from the ticks where the remainder crosses the divisor. The error shows on `out_tick` within one divisor period, which is at most 2^INT_BITS source strobes, and it persists until a select or divisor change clears the accumulator. A wrong source mapping or a missed restart shows on the first affected strobe, one cycle later. The bench keeps its own accumulator and compares every cycle, including the divided output, `busy`, and a pass-through instance. Because of this, a mismatch is caught in the very cycle it first appears.

// File: rtl/fdcm_pkg.sv
package fdcm_pkg;
    // Bit at which the integer part of the divisor begins in the divider word.
    localparam int DIV_ANCHOR = 12;
    localparam int DIV_WORD_W = 32;

    // Fixed low source codes shared by every instance.
    typedef enum int {
        SRC_GND   = 0,
        SRC_OSC   = 1,
        SRC_TEST0 = 2,
        SRC_TEST1 = 3,
        SRC_FIRST_EXT = 4
    } fdcm_src_e;
endpackage

// File: rtl/fdcm_src_select.sv
module fdcm_src_select
    import fdcm_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int NUM_EXT = 2
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               osc_i,
    input  logic               test0_i,
    input  logic               test1_i,
    input  logic [NUM_EXT-1:0] ext_i,
    output logic               tick_o
);
    localparam int NUM_SEL = 1 << SEL_W;

    logic [NUM_SEL-1:0] cand;
    logic               unused_ext;

    assign unused_ext = ^ext_i;

    // Codes 0..3 are fixed, codes from 4 map to instance sources, the rest are ground.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_src
        if (i == int'(SRC_OSC)) begin : g_osc
            assign cand[i] = osc_i;
        end else if (i == int'(SRC_TEST0)) begin : g_t0
            assign cand[i] = test0_i;
        end else if (i == int'(SRC_TEST1)) begin : g_t1
            assign cand[i] = test1_i;
        end else if (i >= int'(SRC_FIRST_EXT) && i < int'(SRC_FIRST_EXT) + NUM_EXT) begin : g_ext
            assign cand[i] = ext_i[i-int'(SRC_FIRST_EXT)];
        end else begin : g_gnd
            assign cand[i] = 1'b0;
        end
    end

    assign tick_o = cand[sel_i];
endmodule

// File: rtl/fdcm_div_field.sv
module fdcm_div_field
    import fdcm_pkg::*;
#(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input  logic [DIV_WORD_W-1:0] word_i,
    output logic [((INT_BITS+FRAC_BITS) > 0 ? (INT_BITS+FRAC_BITS) : 1)-1:0] field_o
);
    localparam int FW   = INT_BITS + FRAC_BITS;
    localparam int FW_O = (FW > 0) ? FW : 1;
    localparam int LO   = DIV_ANCHOR - FRAC_BITS;

    logic unused_word;
    assign unused_word = ^word_i;

    if (FW == 0) begin : g_none
        assign field_o = '0;
    end else begin : g_field
        assign field_o = word_i[LO +: FW_O];
    end
endmodule

// File: rtl/fdcm_phase_acc.sv
module fdcm_phase_acc #(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [((INT_BITS+FRAC_BITS) > 0 ? (INT_BITS+FRAC_BITS) : 1)-1:0] field_i,
    input  logic             tick_i,
    output logic             restart_o,
    output logic             out_o,
    output logic             busy_o
);
    localparam int FW    = INT_BITS + FRAC_BITS;
    localparam int FW_O  = (FW > 0) ? FW : 1;
    localparam int ACC_W = FW_O + 1;
    localparam bit PASS  = (FW == 0);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_BITS;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [FW_O-1:0]  div;
        logic [ACC_W-1:0] acc;
        logic             out;
        logic             busy;
    } acc_state_t;

    acc_state_t       st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;
    logic             restart;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = sel_i;
        st_d.div  = field_i;
        st_d.busy = enable_i;
        st_d.out  = 1'b0;
        div_ext   = {1'b0, field_i};
        sum       = st_q.acc + ONE;
        restart   = (sel_i != st_q.sel) || (field_i != st_q.div);

        if (!enable_i) begin
            st_d.acc = '0;
        end else if (PASS) begin
            st_d.acc = '0;
            st_d.out = tick_i;
        end else if (field_i == '0 || restart) begin
            st_d.acc = '0;
        end else if (tick_i) begin
            if (sum >= div_ext) begin
                st_d.out = 1'b1;
                st_d.acc = (div_ext < ONE) ? '0 : (sum - div_ext);
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart_o = restart;
    assign out_o     = st_q.out;
    assign busy_o    = st_q.busy;
endmodule

// File: rtl/frac_clkdiv_mux.sv
module frac_clkdiv_mux
    import fdcm_pkg::*;
#(
    parameter int SEL_W     = 4,
    parameter int NUM_EXT   = 2,
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_enable,
    input  logic [SEL_W-1:0]      ctl_src_sel,
    input  logic [DIV_WORD_W-1:0] div_word,
    input  logic                  osc_tick,
    input  logic                  test0_tick,
    input  logic                  test1_tick,
    input  logic [NUM_EXT-1:0]    ext_tick,
    output logic                  out_tick,
    output logic                  busy
);
    localparam int FW   = INT_BITS + FRAC_BITS;
    localparam int FW_O = (FW > 0) ? FW : 1;

    logic            sel_tick;
    logic            restart;
    logic [FW_O-1:0] div_field;

    fdcm_src_select #(.SEL_W(SEL_W), .NUM_EXT(NUM_EXT)) u_sel (
        .sel_i   (ctl_src_sel),
        .osc_i   (osc_tick),
        .test0_i (test0_tick),
        .test1_i (test1_tick),
        .ext_i   (ext_tick),
        .tick_o  (sel_tick)
    );

    fdcm_div_field #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_field (
        .word_i  (div_word),
        .field_o (div_field)
    );

    fdcm_phase_acc #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS), .SEL_W(SEL_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (ctl_enable),
        .sel_i     (ctl_src_sel),
        .field_i   (div_field),
        .tick_i    (sel_tick),
        .restart_o (restart),
        .out_o     (out_tick),
        .busy_o    (busy)
    );
endmodule

// File: rtl/frac_clkdiv_mux_chk.sv
module frac_clkdiv_mux_chk #(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_enable,
    input logic [31:0] div_word,
    input logic        sel_tick,
    input logic        restart,
    input logic        out_tick,
    input logic        busy
);
    localparam int FW = INT_BITS + FRAC_BITS;

    // R1: disabled cycle yields no output strobe
    p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !out_tick);

    // R2: busy tracks enable one cycle later
    p_busy_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_enable |=> busy);
    p_busy_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !busy);

    // R6: no output without a picked source strobe
    p_need_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> !out_tick);

    if (FW > 0) begin : g_div_checks
        // R7: zero divisor is silent
        p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (((div_word >> (12 - FRAC_BITS)) & ((32'd1 << FW) - 32'd1)) == 32'd0) |=> !out_tick);
        // R9: a restart cycle drops its strobe
        p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !out_tick);
    end
endmodule

bind frac_clkdiv_mux frac_clkdiv_mux_chk #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .div_word   (div_word),
    .sel_tick   (sel_tick),
    .restart    (restart),
    .out_tick   (out_tick),
    .busy       (busy)
);

// File: tb/frac_clkdiv_mux_tb_top.sv
module frac_clkdiv_mux_tb_top;
    localparam int FRAC = 4;
    localparam int ONE  = 1 << FRAC;

    typedef struct {
        logic  out;
        logic  busy;
        logic  pout;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  sel = '0;
    logic [31:0] dword = '0;
    logic        osc = 1'b0, t0 = 1'b0, t1 = 1'b0;
    logic [1:0]  ext = '0;
    logic        out_tick, busy, pout, pbusy;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    // model state
    int m_acc = 0;
    int m_psel = 0;
    int m_pdiv = 0;

    always #5 clk = ~clk;

    frac_clkdiv_mux #(.SEL_W(4), .NUM_EXT(2), .INT_BITS(4), .FRAC_BITS(FRAC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_enable(en), .ctl_src_sel(sel), .div_word(dword),
        .osc_tick(osc), .test0_tick(t0), .test1_tick(t1), .ext_tick(ext),
        .out_tick(out_tick), .busy(busy)
    );

    frac_clkdiv_mux #(.SEL_W(4), .NUM_EXT(2), .INT_BITS(0), .FRAC_BITS(0)) dut_pass_i (
        .clk(clk), .rst_n(rst_n), .ctl_enable(en), .ctl_src_sel(sel), .div_word(dword),
        .osc_tick(osc), .test0_tick(t0), .test1_tick(t1), .ext_tick(ext),
        .out_tick(pout), .busy(pbusy)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: one cycle of stimulus plus the expected result
    task automatic step(input logic e, input int s, input int v, input string tag);
        logic tk;
        exp_t it;
        @(negedge clk);
        en    = e;
        sel   = 4'(s);
        // junk outside bits 15:8 must not matter (R5)
        dword = {16'hA5C3, 8'(v), 8'hFF};
        osc   = 1'b1;
        t0    = 1'($urandom);
        t1    = 1'($urandom);
        ext   = {1'($urandom), ~ext[0]};
        case (s)
            1: tk = osc;
            2: tk = t0;
            3: tk = t1;
            4: tk = ext[0];
            5: tk = ext[1];
            default: tk = 1'b0;
        endcase
        it.out = 1'b0;
        if (!e) begin
            m_acc = 0;
        end else if (v == 0 || s != m_psel || v != m_pdiv) begin
            m_acc = 0;
        end else if (tk) begin
            if (m_acc + ONE >= v) begin
                it.out = 1'b1;
                m_acc  = (v < ONE) ? 0 : m_acc + ONE - v;
            end else begin
                m_acc = m_acc + ONE;
            end
        end
        m_psel  = s;
        m_pdiv  = v;
        it.busy = e;
        it.pout = e & tk;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic run(input int n, input logic e, input int s, input int v, input string tag);
        for (int i = 0; i < n; i++) step(e, s, v, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(it.tag, out_tick, it.out);
                check("R2", busy, it.busy);
                check("R10", pout, it.pout);
            end
        end
    end

    // watchdog
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", out_tick, 1'b0);
        check("R2", busy, 1'b0);
        rst_n = 1'b1;
        run(6, 1'b0, 1, 48, "R1");
        run(30, 1'b1, 1, 48, "R6");    // 3.0
        run(40, 1'b1, 1, 40, "R6");    // 2.5
        run(40, 1'b1, 2, 28, "R5");    // 1.75 on test0
        run(20, 1'b1, 0, 48, "R3");    // ground
        run(30, 1'b1, 3, 24, "R3");
        run(30, 1'b1, 4, 20, "R3");
        run(30, 1'b1, 5, 33, "R3");
        run(20, 1'b1, 9, 16, "R4");
        run(20, 1'b1, 15, 16, "R4");
        run(20, 1'b1, 1, 0, "R7");
        run(20, 1'b1, 1, 8, "R8");
        run(20, 1'b1, 2, 1, "R8");
        run(7, 1'b1, 1, 48, "R9");
        run(1, 1'b1, 1, 40, "R9");
        run(9, 1'b1, 1, 40, "R9");
        run(1, 1'b1, 2, 40, "R9");
        run(9, 1'b1, 2, 40, "R9");
        run(5, 1'b0, 1, 40, "R1");
        for (int k = 0; k < 12; k++) step(1'(k % 2), 1, 40, "R2");
        run(30, 1'b1, 5, 17, "R6");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule